// File: doc/BRIEF.md
# Inbound Packet Acceptance and Message Tracker

This block sits on the receive side of a serial packet endpoint, after the line decoding and the integrity checks. Each cycle it can take one decoded packet header. A header carries a destination ID, a message ID, a segment index, a last-segment flag and a payload byte count. The block compares the destination ID with one or two programmable device IDs and checks the payload length. It then accepts or drops the packet. Every accepted packet raises a single-cycle transfer request toward the DMA engine, which moves that payload into on-chip memory.

Messages can span several packets. Each message ID has its own tracking slot, and a slot expects its segments in increasing order starting from zero. The CPU interrupt comes only once per message, when the final segment has been accepted in order. The interrupt is a level output driven by a sticky pending bit, and software clears that bit by writing one to it. A segment that arrives out of order aborts its message and sets a sticky error bit. A dropped packet increments a saturating counter and leaves the tracking state untouched.

The header input is a valid/ready stream. The block keeps `hdr_ready` high at all times, so a header is consumed in every cycle in which `hdr_valid` is high. The source never sees back-pressure and never needs to hold a header for more than one cycle. The DMA request and the register port are plain signals.

Top module: `pkt_accept_tracker`

## Requirements
- R1: After reset the primary ID (address 0x80) and the secondary ID (address 0x84) read 0xFFFF. The control register (address 0x88, bit 0 = filter mode) reads 0. The status register (address 0x8C) and the drop counter (address 0x90) read 0. `irq` and `dma_req` are low.
- R2: With mode bit 0, a header is accepted only if its destination ID equals the primary ID. A header that matches only the secondary ID is dropped.
- R3: With mode bit 1, a header is accepted if its destination ID equals either the primary ID or the secondary ID.
- R4: A header with a payload length of 257 or more is dropped, whatever its ID, and sets status bit 1 (length error, sticky). A length of exactly 256 is accepted.
- R5: Each accepted header produces exactly one `dma_req` pulse one cycle wide, in the cycle after the header is taken. `dma_msg` and `dma_len` carry that header's message ID and length. A dropped header produces no pulse.
- R6: Each dropped header increments the 16-bit drop counter. The counter stops at 0xFFFF.
- R7: `irq` goes high in the cycle after the last segment (last flag = 1) of a message is accepted, provided every segment from 0 upward arrived in order. Earlier segments of that message leave `irq` low.
- R8: An accepted segment whose index differs from the expected one (a skipped or repeated segment) sets status bit 2 (sequence error, sticky) and aborts the message. That slot then expects segment 0 again, and a later last segment of the aborted message does not interrupt.
- R9: An in-order segment with index 15 and the last flag clear is a sequence error, with the same effect as R8.
- R10: Status bit 0 is the interrupt pending bit, and `irq` follows it. Writing 1 to status bits 0, 1 or 2 clears them. If a completion happens in the same cycle as a clear of bit 0, the bit stays set.
- R11: The four message IDs (0 to 3) are tracked independently, so interleaved segments of different messages do not disturb one another.
- R12: `hdr_ready` is always high, and a header is taken in every cycle in which `hdr_valid` is high, including back-to-back cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Header present this cycle |
| hdr_ready | output | 1 | Header can be taken (always high) |
| hdr_dest | input | 16 | Destination ID |
| hdr_msg | input | 2 | Message ID |
| hdr_seg | input | 4 | Segment index within the message |
| hdr_last | input | 1 | Final segment of the message |
| hdr_len | input | 9 | Payload byte count |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational from reg_addr) |
| dma_req | output | 1 | One-cycle transfer request |
| dma_msg | output | 2 | Message ID of the request |
| dma_len | output | 9 | Payload length of the request |
| irq | output | 1 | Message-complete interrupt (level) |

## Verification
The filter is driven with headers addressed to the primary ID, to the secondary ID and to neither, in both modes. This separates a correct mode decode from a filter that always or never accepts the secondary ID. Payload lengths of 256 and 257 locate the length boundary exactly. Messages are sent in order, with a skipped segment, with a repeated segment and with a non-final segment 15. These patterns show whether the tracker interrupts only on a clean completion and restarts properly after an abort. Interleaved segments of all four message IDs and a completion that lands on the same cycle as a clear of the pending bit test slot independence and set priority. A long run of dropped headers pushes the counter into saturation.

// File: rtl/pat_pkg.sv
package pat_pkg;
  localparam int ID_W    = 16;
  localparam int MSG_W   = 2;
  localparam int SEG_W   = 4;
  localparam int LEN_W   = 9;
  localparam int MAX_LEN = 256;
  localparam int CNT_W   = 16;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 16;
  localparam int NSLOT   = 1 << MSG_W;

  localparam logic [ADDR_W-1:0] A_PRIM = 8'h80;
  localparam logic [ADDR_W-1:0] A_SEC  = 8'h84;
  localparam logic [ADDR_W-1:0] A_CTRL = 8'h88;
  localparam logic [ADDR_W-1:0] A_STAT = 8'h8C;
  localparam logic [ADDR_W-1:0] A_DROP = 8'h90;

  typedef struct packed {
    logic [ID_W-1:0]  dest;
    logic [MSG_W-1:0] msg;
    logic [SEG_W-1:0] seg;
    logic             last;
    logic [LEN_W-1:0] len;
  } hdr_t;
endpackage

// File: rtl/pat_id_filter.sv
module pat_id_filter
  import pat_pkg::*;
(
  input  logic            take,
  input  hdr_t            hdr,
  input  logic [ID_W-1:0] prim_id,
  input  logic [ID_W-1:0] sec_id,
  input  logic            mode,
  output logic            accept,
  output logic            drop,
  output logic            len_bad
);
  logic hit_prim, hit_sec, id_ok, len_ok;

  always_comb begin
    hit_prim = (hdr.dest == prim_id);
    hit_sec  = mode && (hdr.dest == sec_id);
    id_ok    = hit_prim || hit_sec;
    len_ok   = ({1'b0, hdr.len} <= (LEN_W+1)'(MAX_LEN));
    accept   = take && id_ok && len_ok;
    drop     = take && !(id_ok && len_ok);
    len_bad  = take && !len_ok;
  end
endmodule

// File: rtl/pat_msg_tracker.sv
module pat_msg_tracker
  import pat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic [MSG_W-1:0] msg,
  input  logic [SEG_W-1:0] seg,
  input  logic             last,
  output logic             done,
  output logic             seq_err
);
  localparam logic [SEG_W-1:0] SEG_MAX = {SEG_W{1'b1}};

  logic [SEG_W-1:0] exp_q [NSLOT];
  logic             in_order, bad;

  always_comb begin
    in_order = (seg == exp_q[msg]);
    bad      = !in_order || (seg == SEG_MAX && !last);
    done     = acc && in_order && last;
    seq_err  = acc && bad;
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic hit;
    assign hit = acc && (msg == MSG_W'(s));
    always_ff @(posedge clk) begin
      if (!rst_n)
        exp_q[s] <= '0;
      else if (hit) begin
        if (bad || last) exp_q[s] <= '0;
        else             exp_q[s] <= seg + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pat_csr.sv
module pat_csr
  import pat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              drop,
  input  logic              len_bad,
  input  logic              done,
  input  logic              seq_err,
  output logic [ID_W-1:0]   prim_id,
  output logic [ID_W-1:0]   sec_id,
  output logic              mode,
  output logic [CNT_W-1:0]  drop_cnt,
  output logic              pend
);
  logic lerr_q, serr_q;
  logic wr_stat;

  assign wr_stat = reg_we && (reg_addr == A_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prim_id <= '1;
      sec_id  <= '1;
      mode    <= 1'b0;
    end else if (reg_we) begin
      if (reg_addr == A_PRIM) prim_id <= reg_wdata[ID_W-1:0];
      if (reg_addr == A_SEC)  sec_id  <= reg_wdata[ID_W-1:0];
      if (reg_addr == A_CTRL) mode    <= reg_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      drop_cnt <= '0;
    else if (drop && drop_cnt != {CNT_W{1'b1}})
      drop_cnt <= drop_cnt + 1'b1;
  end

  // set has priority over the write-one clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      lerr_q <= 1'b0;
      serr_q <= 1'b0;
    end else begin
      if (done)                         pend <= 1'b1;
      else if (wr_stat && reg_wdata[0]) pend <= 1'b0;
      if (len_bad)                      lerr_q <= 1'b1;
      else if (wr_stat && reg_wdata[1]) lerr_q <= 1'b0;
      if (seq_err)                      serr_q <= 1'b1;
      else if (wr_stat && reg_wdata[2]) serr_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_PRIM:  reg_rdata = DATA_W'(prim_id);
      A_SEC:   reg_rdata = DATA_W'(sec_id);
      A_CTRL:  reg_rdata = DATA_W'(mode);
      A_STAT:  reg_rdata = DATA_W'({serr_q, lerr_q, pend});
      A_DROP:  reg_rdata = DATA_W'(drop_cnt);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pkt_accept_tracker.sv
module pkt_accept_tracker
  import pat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_valid,
  output logic              hdr_ready,
  input  logic [ID_W-1:0]   hdr_dest,
  input  logic [MSG_W-1:0]  hdr_msg,
  input  logic [SEG_W-1:0]  hdr_seg,
  input  logic              hdr_last,
  input  logic [LEN_W-1:0]  hdr_len,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              dma_req,
  output logic [MSG_W-1:0]  dma_msg,
  output logic [LEN_W-1:0]  dma_len,
  output logic              irq
);
  hdr_t             hdr;
  logic             take, accept, drop, len_bad, done, seq_err, mode, pend;
  logic [ID_W-1:0]  prim_id, sec_id;
  logic [CNT_W-1:0] drop_cnt;

  assign hdr_ready = 1'b1;
  assign take      = hdr_valid && hdr_ready;
  assign hdr       = '{dest: hdr_dest, msg: hdr_msg, seg: hdr_seg,
                       last: hdr_last, len: hdr_len};

  pat_id_filter u_filt (
    .take(take), .hdr(hdr), .prim_id(prim_id), .sec_id(sec_id),
    .mode(mode), .accept(accept), .drop(drop), .len_bad(len_bad)
  );

  pat_msg_tracker u_trk (
    .clk(clk), .rst_n(rst_n), .acc(accept), .msg(hdr.msg),
    .seg(hdr.seg), .last(hdr.last), .done(done), .seq_err(seq_err)
  );

  pat_csr u_csr (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .drop(drop),
    .len_bad(len_bad), .done(done), .seq_err(seq_err),
    .prim_id(prim_id), .sec_id(sec_id), .mode(mode),
    .drop_cnt(drop_cnt), .pend(pend)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dma_req <= 1'b0;
      dma_msg <= '0;
      dma_len <= '0;
    end else begin
      dma_req <= accept;
      if (accept) begin
        dma_msg <= hdr.msg;
        dma_len <= hdr.len;
      end
    end
  end

  assign irq = pend;
endmodule

// File: rtl/pat_checker.sv
module pat_checker
  import pat_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             hdr_valid,
  input logic [ID_W-1:0]  hdr_dest,
  input logic [LEN_W-1:0] hdr_len,
  input logic [ID_W-1:0]  prim_id,
  input logic             mode,
  input logic             dma_req,
  input logic             irq,
  input logic [CNT_W-1:0] drop_cnt
);
  // R5
  dma_after_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> $past(hdr_valid));

  // R4
  len_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && {1'b0, hdr_len} > (LEN_W+1)'(MAX_LEN)) |=> !dma_req);

  // R2
  uni_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && !mode && hdr_dest != prim_id) |=> !dma_req);

  // R7
  irq_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> dma_req);

  // R6
  drop_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_cnt == {CNT_W{1'b1}}) |=> (drop_cnt == {CNT_W{1'b1}}));

  // R6
  drop_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_cnt != {CNT_W{1'b1}}) |=> (drop_cnt >= $past(drop_cnt)));
endmodule

bind pkt_accept_tracker pat_checker chk_i (
  .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_dest(hdr_dest),
  .hdr_len(hdr_len), .prim_id(prim_id), .mode(mode), .dma_req(dma_req),
  .irq(irq), .drop_cnt(drop_cnt)
);

// File: tb/pkt_accept_tracker_tb_top.sv
module pkt_accept_tracker_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hdr_valid = 1'b0, hdr_last = 1'b0, reg_we = 1'b0;
  logic [15:0] hdr_dest = '0, reg_wdata = '0;
  logic [1:0]  hdr_msg = '0;
  logic [3:0]  hdr_seg = '0;
  logic [8:0]  hdr_len = '0;
  logic [7:0]  reg_addr = '0;
  logic [15:0] reg_rdata;
  logic        hdr_ready, dma_req, irq;
  logic [1:0]  dma_msg;
  logic [8:0]  dma_len;

  int n_chk = 0, n_fail = 0;
  int exp_drop = 0;
  logic [10:0] sb_q [$];

  always #2 clk = ~clk;

  pkt_accept_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
    .hdr_dest(hdr_dest), .hdr_msg(hdr_msg), .hdr_seg(hdr_seg),
    .hdr_last(hdr_last), .hdr_len(hdr_len), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dma_req(dma_req), .dma_msg(dma_msg), .dma_len(dma_len), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  // monitor: every dma pulse must match the oldest expected item (R5)
  always @(negedge clk) begin
    if (rst_n && dma_req) begin
      if (sb_q.size() == 0) check("R5 unexpected dma_req", 1, 0);
      else begin
        logic [10:0] e;
        e = sb_q.pop_front();
        check("R5 dma msg/len", {dma_msg, dma_len}, e);
      end
    end
  end

  task automatic send(logic [15:0] d, logic [1:0] m, logic [3:0] s,
                      logic l, logic [8:0] n, bit acc);
    @(negedge clk);
    reg_we = 1'b0;
    hdr_valid = 1'b1; hdr_dest = d; hdr_msg = m; hdr_seg = s;
    hdr_last = l; hdr_len = n;
    if (acc) sb_q.push_back({m, n});
    else if (exp_drop < 65535) exp_drop++;
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] v);
    @(negedge clk);
    hdr_valid = 1'b0; reg_we = 1'b1; reg_addr = a; reg_wdata = v;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [15:0] exp);
    @(negedge clk);
    hdr_valid = 1'b0; reg_we = 1'b0; reg_addr = a;
    #1 check(req, reg_rdata, exp);
  endtask

  task automatic irq_chk(string req, logic exp);
    @(negedge clk);
    hdr_valid = 1'b0; reg_we = 1'b0;
    #1 check(req, irq, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check("watchdog", 1, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, R12 ready
    rd_chk("R1 prim id", 8'h80, 16'hFFFF);
    rd_chk("R1 sec id", 8'h84, 16'hFFFF);
    rd_chk("R1 ctrl", 8'h88, 16'h0000);
    rd_chk("R1 status", 8'h8C, 16'h0000);
    rd_chk("R1 drop", 8'h90, 16'h0000);
    check("R1 irq", irq, 0);
    check("R1 dma_req", dma_req, 0);
    check("R12 ready", hdr_ready, 1);

    wr(8'h80, 16'h0012);
    wr(8'h84, 16'h0034);
    // R2 unicast mode
    send(16'h0012, 2'd0, 4'd0, 1'b1, 9'd64, 1);
    send(16'h0034, 2'd1, 4'd0, 1'b1, 9'd8, 0);
    send(16'h0099, 2'd1, 4'd0, 1'b1, 9'd8, 0);
    irq_chk("R7 single-segment irq", 1);
    rd_chk("R2 drops in mode 0", 8'h90, 16'd2);
    wr(8'h8C, 16'h0001);
    irq_chk("R10 clear pending", 0);

    // R3 multicast mode, back-to-back headers (R12)
    wr(8'h88, 16'h0001);
    send(16'h0034, 2'd1, 4'd0, 1'b0, 9'd16, 1);
    send(16'h0012, 2'd1, 4'd1, 1'b0, 9'd17, 1);
    send(16'h0099, 2'd1, 4'd2, 1'b0, 9'd18, 0);
    rd_chk("R3 drops in mode 1", 8'h90, 16'd3);

    // R4 length boundary
    send(16'h0012, 2'd0, 4'd0, 1'b0, 9'd256, 1);
    rd_chk("R4 no len error at 256", 8'h8C, 16'h0000);
    send(16'h0012, 2'd0, 4'd1, 1'b0, 9'd257, 0);
    rd_chk("R4 len error bit", 8'h8C, 16'h0002);
    rd_chk("R4 drop counted", 8'h90, 16'd4);
    wr(8'h8C, 16'h0002);
    rd_chk("R10 clear len error", 8'h8C, 16'h0000);

    // R7 multi-segment: message 0 resumes at seg 1 (the 257 drop did not advance it)
    send(16'h0012, 2'd0, 4'd1, 1'b0, 9'd32, 1);
    irq_chk("R7 no irq mid message", 0);
    send(16'h0012, 2'd0, 4'd2, 1'b1, 9'd33, 1);
    irq_chk("R7 irq after last", 1);
    wr(8'h8C, 16'h0001);

    // R11 interleaved slots; msg 1 is expecting seg 2
    send(16'h0012, 2'd2, 4'd0, 1'b0, 9'd1, 1);
    send(16'h0012, 2'd3, 4'd0, 1'b0, 9'd2, 1);
    send(16'h0012, 2'd0, 4'd0, 1'b0, 9'd3, 1);
    send(16'h0012, 2'd1, 4'd2, 1'b0, 9'd4, 1);
    send(16'h0012, 2'd2, 4'd1, 1'b1, 9'd5, 1);
    irq_chk("R11 msg2 completes among others", 1);
    rd_chk("R11 no sequence error", 8'h8C, 16'h0001);
    wr(8'h8C, 16'h0001);
    send(16'h0012, 2'd0, 4'd1, 1'b1, 9'd6, 1);
    irq_chk("R11 msg0 completes", 1);
    wr(8'h8C, 16'h0001);

    // R8 skipped segment aborts msg 3 (expects seg 1)
    send(16'h0012, 2'd3, 4'd3, 1'b0, 9'd7, 1);
    rd_chk("R8 sequence error bit", 8'h8C, 16'h0004);
    send(16'h0012, 2'd3, 4'd4, 1'b1, 9'd8, 1);
    irq_chk("R8 aborted message silent", 0);
    wr(8'h8C, 16'h0004);
    send(16'h0012, 2'd3, 4'd0, 1'b0, 9'd9, 1);
    send(16'h0012, 2'd3, 4'd0, 1'b1, 9'd10, 1);
    irq_chk("R8 repeated segment no irq", 0);
    rd_chk("R8 repeat flagged", 8'h8C, 16'h0004);
    wr(8'h8C, 16'h0004);
    send(16'h0012, 2'd3, 4'd0, 1'b1, 9'd11, 1);
    irq_chk("R8 restart from seg 0", 1);
    wr(8'h8C, 16'h0001);

    // R9 seg 15 without last on msg 1 (reset slot first via error)
    send(16'h0012, 2'd1, 4'd9, 1'b0, 9'd1, 1);
    wr(8'h8C, 16'h0004);
    for (int s = 0; s < 16; s++)
      send(16'h0012, 2'd1, 4'(s), 1'b0, 9'd20, 1);
    irq_chk("R9 no irq", 0);
    rd_chk("R9 seg15 non-last error", 8'h8C, 16'h0004);
    wr(8'h8C, 16'h0004);
    send(16'h0012, 2'd1, 4'd0, 1'b1, 9'd21, 1);
    irq_chk("R9 slot restarted", 1);

    // R10 completion wins over same-cycle clear
    wr(8'h8C, 16'h0001);
    send(16'h0012, 2'd2, 4'd0, 1'b1, 9'd22, 1);
    reg_we = 1'b1; reg_addr = 8'h8C; reg_wdata = 16'h0001;
    irq_chk("R10 set beats clear", 1);
    wr(8'h8C, 16'h0001);
    irq_chk("R10 later clear", 0);

    // R6 saturation
    for (int i = 0; i < 65540; i++)
      send(16'h0777, 2'd0, 4'd0, 1'b0, 9'd1, 0);
    rd_chk("R6 drop counter saturates", 8'h90, 16'(exp_drop));
    rd_chk("R6 value 0xFFFF", 8'h90, 16'hFFFF);

    irq_chk("R5 idle", 0);
    check("R5 all requests seen", sb_q.size(), 0);
    summary();
  end
endmodule